// File: doc/BRIEF.md
# Radix-2 SRT Unsigned Integer Divider

This block divides one unsigned W-bit operand by another and returns a W-bit quotient and a W-bit remainder. It uses radix-2 SRT division with the redundant digit set {-1, 0, +1}. Each digit is chosen from only the three most significant bits of a signed partial remainder, so no full-width comparison is needed in the loop.

The divider first counts the leading zeros of the divisor and shifts both operands left by that amount. It then performs W digit iterations, UNROLL of them per clock. A final cycle turns the positive and negative digit strings into a binary quotient, corrects a negative remainder, and shifts the remainder back to undo the normalization. The partial-remainder register is 2W+1 bits wide. Its low W bits double as the positive-digit string.

A caller raises `start` for one cycle while `busy` is low, with the operands on the inputs. Later it collects the result when the one-cycle `done` pulse appears. A zero divisor skips the iterations.

Top module: `srt_divider`

## Requirements
- R1: After reset, `busy`, `done`, `quotient` and `remainder` are all zero.
- R2: A `start` seen on a rising edge while `busy` is low and `divisor` is nonzero makes `busy` high from the next cycle until the result is delivered.
- R3: For a nonzero divisor, `done` is high in the cycle after the (W/UNROLL + 2)-th rising edge, counting the accepting edge as the first; `busy` falls on that same edge.
- R4: For a nonzero divisor, `quotient` equals floor(dividend / divisor) for the operands captured at acceptance.
- R5: For a nonzero divisor, `remainder` equals dividend mod divisor, which is strictly less than the divisor.
- R6: R4 and R5 hold for every normalization shift from 0 to W-1, including a divisor with its top bit set, a divisor of one, and an all-ones dividend.
- R7: A zero divisor never raises `busy`. `done` is high in the cycle right after the accepting edge, with `quotient` all ones and `remainder` equal to the dividend.
- R8: `start` and operand changes while `busy` is high have no effect: the running operation's result is unchanged and no extra operation follows it.
- R9: `done` stays high for exactly one cycle and is never high together with `busy`.
- R10: `quotient` and `remainder` change only on the edge that raises `done`, and hold their values until the next completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request a division using the present operands |
| dividend | input | W | Unsigned dividend |
| divisor | input | W | Unsigned divisor |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse: result valid and updated |
| quotient | output | W | Unsigned quotient |
| remainder | output | W | Unsigned remainder |

## Verification
The bench aims at the extremes of normalization. A divisor of one gives the largest shift, and a divisor with its top bit set gives no shift. A mistake in denormalizing the remainder leaves a result scaled by a power of two, and a missing negative-remainder correction makes the quotient one too high with a remainder that has wrapped. A zero divisor must bypass the loop. A design that let it iterate would return garbage late and raise `busy`. The bench also toggles `start` with different operands in the middle of an operation. A design that captured them would corrupt the running result or launch a second, unrequested operation, which shows up as a spurious `done`.

// File: rtl/srt_div_pkg.sv
package srt_div_pkg;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_ITER,
        PH_FIX
    } phase_e;

    typedef enum logic [1:0] {
        DIG_ZERO,
        DIG_POS,
        DIG_NEG
    } digit_e;

    // Digit choice from the three top bits of the signed partial remainder.
    function automatic digit_e pick_digit(input logic [2:0] top);
        digit_e d;
        unique case (top)
            3'b001, 3'b010, 3'b011: d = DIG_POS;
            3'b100, 3'b101, 3'b110: d = DIG_NEG;
            default:                d = DIG_ZERO;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/srt_div_lzc.sv
module srt_div_lzc #(
    parameter int W  = 8,
    localparam int KW = (W > 2) ? $clog2(W) : 1
) (
    input  logic [W-1:0]  vec,
    output logic [KW-1:0] zeros
);
    logic seen;

    always_comb begin
        zeros = '0;
        seen  = 1'b0;
        for (int i = W - 1; i >= 0; i--) begin
            if (!seen) begin
                if (vec[i]) seen = 1'b1;
                else        zeros = zeros + 1'b1;
            end
        end
    end
endmodule

// File: rtl/srt_div_step.sv
module srt_div_step
    import srt_div_pkg::*;
#(
    parameter int W  = 8,
    localparam int PW = 2 * W + 1
) (
    input  logic [PW-1:0] pr_i,
    input  logic [W-1:0]  an_i,
    input  logic [W-1:0]  dn_i,
    output logic [PW-1:0] pr_o,
    output logic [W-1:0]  an_o
);
    logic [PW-1:0] shifted;
    logic [PW-1:0] dext;
    digit_e        dig;

    assign shifted = {pr_i[PW-2:0], 1'b0};
    assign dext    = {1'b0, dn_i, {W{1'b0}}};
    assign dig     = pick_digit(pr_i[PW-1:PW-3]);

    always_comb begin
        pr_o = shifted;
        an_o = {an_i[W-2:0], 1'b0};
        unique case (dig)
            DIG_POS: begin
                pr_o    = shifted - dext;
                pr_o[0] = 1'b1;
            end
            DIG_NEG: begin
                pr_o = shifted + dext;
                an_o = {an_i[W-2:0], 1'b1};
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/srt_divider.sv
module srt_divider
    import srt_div_pkg::*;
#(
    parameter int W      = 8,
    parameter int UNROLL = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] quotient,
    output logic [W-1:0] remainder
);
    localparam int PW    = 2 * W + 1;
    localparam int ITERS = W / UNROLL;
    localparam int KW    = (W > 2) ? $clog2(W) : 1;
    localparam int CW    = (ITERS > 1) ? $clog2(ITERS) : 1;

    phase_e        phase_q;
    logic [PW-1:0] pr_q;
    logic [W-1:0]  an_q;
    logic [W-1:0]  dn_q;
    logic [KW-1:0] k_q;
    logic [CW-1:0] it_q;
    logic [KW-1:0] k_w;

    logic [PW-1:0] pr_c [UNROLL+1];
    logic [W-1:0]  an_c [UNROLL+1];

    logic          neg;
    logic [W-1:0]  q_fix;
    logic [W-1:0]  r_fix;

    srt_div_lzc #(.W(W)) u_lzc (
        .vec   (divisor),
        .zeros (k_w)
    );

    assign pr_c[0] = pr_q;
    assign an_c[0] = an_q;

    for (genvar g = 0; g < UNROLL; g++) begin : g_step
        srt_div_step #(.W(W)) u_step (
            .pr_i (pr_c[g]),
            .an_i (an_c[g]),
            .dn_i (dn_q),
            .pr_o (pr_c[g+1]),
            .an_o (an_c[g+1])
        );
    end

    // Final conversion: low W bits hold the positive digits.
    assign neg   = pr_q[PW-1];
    assign q_fix = pr_q[W-1:0] - an_q - W'(neg);
    assign r_fix = pr_q[2*W-1:W] + (neg ? dn_q : '0);

    assign busy = (phase_q != PH_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q   <= PH_IDLE;
            pr_q      <= '0;
            an_q      <= '0;
            dn_q      <= '0;
            k_q       <= '0;
            it_q      <= '0;
            quotient  <= '0;
            remainder <= '0;
            done      <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (phase_q)
                PH_IDLE: begin
                    if (start) begin
                        if (divisor == '0) begin
                            quotient  <= '1;
                            remainder <= dividend;
                            done      <= 1'b1;
                        end else begin
                            pr_q    <= PW'(dividend) << k_w;
                            dn_q    <= divisor << k_w;
                            k_q     <= k_w;
                            an_q    <= '0;
                            it_q    <= CW'(ITERS - 1);
                            phase_q <= PH_ITER;
                        end
                    end
                end
                PH_ITER: begin
                    pr_q <= pr_c[UNROLL];
                    an_q <= an_c[UNROLL];
                    if (it_q == '0) phase_q <= PH_FIX;
                    else            it_q    <= it_q - 1'b1;
                end
                PH_FIX: begin
                    quotient  <= q_fix;
                    remainder <= r_fix >> k_q;
                    done      <= 1'b1;
                    phase_q   <= PH_IDLE;
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/srt_divider_chk.sv
module srt_divider_chk #(
    parameter int W      = 8,
    parameter int UNROLL = 2
) (
    input logic         clk,
    input logic         rst,
    input logic         start,
    input logic [W-1:0] dividend,
    input logic [W-1:0] divisor,
    input logic         busy,
    input logic         done,
    input logic [W-1:0] quotient,
    input logic [W-1:0] remainder
);
    localparam int ITERS = W / UNROLL;
    localparam int SW    = $clog2(ITERS + 3);
    localparam int XW    = 2 * W + 1;

    logic [SW-1:0] since;
    logic          op_valid;
    logic [W-1:0]  op_num;
    logic [W-1:0]  op_den;
    logic          accept;

    assign accept = start && !busy && (divisor != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            since    <= '0;
            op_valid <= 1'b0;
            op_num   <= '0;
            op_den   <= '0;
        end else begin
            if (accept) begin
                since    <= '0;
                op_valid <= 1'b1;
                op_num   <= dividend;
                op_den   <= divisor;
            end else begin
                if (busy) since <= since + 1'b1;
                if (done) op_valid <= 1'b0;
            end
        end
    end

    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
        accept |=> busy); // R2

    AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (done && since == SW'(ITERS + 1))); // R3

    AST_QUOT_EXACT: assert property (@(posedge clk) disable iff (rst)
        (done && op_valid) |->
        (XW'(quotient) * XW'(op_den) + XW'(remainder) == XW'(op_num))); // R4

    AST_REM_BOUND: assert property (@(posedge clk) disable iff (rst)
        (done && op_valid) |-> (remainder < op_den)); // R5

    AST_ZERO_DIVISOR: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && divisor == '0) |=>
        (done && !busy && quotient == '1 && remainder == $past(dividend))); // R7

    AST_BUSY_BOUNDED: assert property (@(posedge clk) disable iff (rst)
        busy |-> (since <= SW'(ITERS + 1))); // R8

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R9

    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy); // R9

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(quotient) && $stable(remainder))); // R10
endmodule

bind srt_divider srt_divider_chk #(.W(W), .UNROLL(UNROLL)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .dividend  (dividend),
    .divisor   (divisor),
    .busy      (busy),
    .done      (done),
    .quotient  (quotient),
    .remainder (remainder)
);

// File: tb/test_srt_divider.sv
module test_srt_divider;
    localparam int W      = 8;
    localparam int UNROLL = 2;
    localparam int ITERS  = W / UNROLL;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [W-1:0] dividend = '0;
    logic [W-1:0] divisor = '0;
    logic         busy;
    logic         done;
    logic [W-1:0] quotient;
    logic [W-1:0] remainder;

    int compared   = 0;
    int mismatched = 0;

    srt_divider #(.W(W), .UNROLL(UNROLL)) i_srt_divider (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .dividend  (dividend),
        .divisor   (divisor),
        .busy      (busy),
        .done      (done),
        .quotient  (quotient),
        .remainder (remainder)
    );

    always #4 clk = ~clk;

    // Behavioural reference, advanced on every rising edge.
    logic         ebusy = 1'b0;
    logic         edone = 1'b0;
    logic [W-1:0] equo = '0;
    logic [W-1:0] erem = '0;
    logic [W-1:0] pend_q = '0;
    logic [W-1:0] pend_r = '0;
    int           left = 0;
    logic         armed = 1'b0;

    always @(posedge clk) begin
        armed <= 1'b1;
        if (rst) begin
            ebusy <= 1'b0;
            edone <= 1'b0;
            equo  <= '0;
            erem  <= '0;
            left  <= 0;
        end else begin
            edone <= 1'b0;
            if (ebusy) begin
                if (left == 1) begin
                    ebusy <= 1'b0;
                    edone <= 1'b1;
                    equo  <= pend_q;
                    erem  <= pend_r;
                end
                left <= left - 1;
            end else if (start) begin
                if (divisor == '0) begin
                    edone <= 1'b1;
                    equo  <= '1;
                    erem  <= dividend;
                end else begin
                    ebusy  <= 1'b1;
                    left   <= ITERS + 1;
                    pend_q <= dividend / divisor;
                    pend_r <= dividend % divisor;
                end
            end
        end
    end

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (armed) begin
            check("R2 busy", W'(busy), W'(ebusy));
            check("R3 done", W'(done), W'(edone));
            check("R4 quotient", quotient, equo);
            check("R5 remainder", remainder, erem);
        end
    end

    task automatic wait_done();
        int guard = 0;
        while (!done && guard < 50) begin
            @(negedge clk);
            guard++;
        end
    endtask

    task automatic divide(input logic [W-1:0] n, input logic [W-1:0] d, input string tag);
        @(negedge clk);
        start    = 1'b1;
        dividend = n;
        divisor  = d;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        if (d == '0) begin
            check({tag, " zero-divisor quotient"}, quotient, '1);
            check({tag, " zero-divisor remainder"}, remainder, n);
        end else begin
            check({tag, " quotient"}, quotient, n / d);
            check({tag, " remainder"}, remainder, n % d);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 busy", W'(busy), '0);
        check("R1 done", W'(done), '0);
        check("R1 quotient", quotient, '0);
        check("R1 remainder", remainder, '0);
        rst = 1'b0;

        // R6 normalization extremes
        divide(8'd255, 8'd1, "R6");
        divide(8'd255, 8'd128, "R6");
        divide(8'd200, 8'd255, "R6");
        divide(8'd255, 8'd255, "R6");
        divide(8'd0, 8'd7, "R6");
        divide(8'd100, 8'd3, "R6");
        for (int s = 0; s < W; s++) divide(8'd251, 8'(1 << s) | 8'(s), "R6");

        // R7 zero divisor
        divide(8'd173, 8'd0, "R7");
        check("R7 busy stays low", W'(busy), '0);

        // R8 start during busy is ignored
        @(negedge clk);
        start = 1'b1; dividend = 8'd250; divisor = 8'd7;
        @(negedge clk);
        dividend = 8'd9; divisor = 8'd2;
        @(negedge clk);
        dividend = 8'd1; divisor = 8'd0;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        check("R8 quotient", quotient, 8'd35);
        check("R8 remainder", remainder, 8'd5);
        @(negedge clk);
        check("R9 done single", W'(done), '0);
        check("R8 no extra op", W'(busy), '0);

        // R10 outputs hold while idle with moving operands
        for (int i = 0; i < 5; i++) begin
            dividend = 8'(i * 37);
            divisor  = 8'(i);
            @(negedge clk);
        end
        check("R10 quotient hold", quotient, 8'd35);
        check("R10 remainder hold", remainder, 8'd5);

        // Mixed random operands
        for (int i = 0; i < 400; i++) begin
            logic [W-1:0] n;
            logic [W-1:0] d;
            n = 8'($urandom);
            unique case (i % 4)
                0:       d = 8'($urandom_range(1, 3));
                1:       d = 8'($urandom) | 8'h80;
                default: d = 8'($urandom);
            endcase
            if (i % 17 == 0) d = '0;
            divide(n, d, "R4/R5 random");
        end

        repeat (3) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog expired: actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule